// File: doc/BRIEF.md
# Indexed Configuration Port with Key Unlock

This block is the host-facing configuration register file of a multi-function I/O controller. The host reaches it through two byte-wide bus addresses: an index port and a data port. The configuration space stays hidden until the host writes an enable key to the index port twice in a row. After that, every access is a register number written to the index port followed by a read or a write on the data port. A single write of a disable key to the index port hides the space again.

One global register picks the active logical device. Device-specific register numbers then reach the bank of that device. Each bank holds an enable bit, a 16-bit I/O base address split into high and low bytes, and an interrupt select byte. These values are also driven out to the device logic. Read-only global registers return a 16-bit chip identifier, a 16-bit vendor identifier and the state of the port-pair strap. One designated device also carries a byte of wake-enable bits that can only be set; only reset clears them. A strap input picks which of two address pairs the port answers on.

Top module: `sio_cfg_port`

## Requirements
- R1: The configuration space opens (cfg_mode=1, visible in the cycle after the write) only when the enable key (default 0x87) has been written to the index port on two consecutive writes to the decoded pair. A single key write leaves cfg_mode at 0.
- R2: While the space is locked, any write to the decoded pair other than the enable key to the index port restarts the key sequence, so two more key writes are then needed.
- R3: While the space is open, writing the disable key (default 0xAA) to the index port closes it in the next cycle and leaves the index register unchanged. Any other byte written there becomes the index, and a read of the index port returns it.
- R4: While the space is locked, data-port reads return 0xFF and data-port writes change no register and no output.
- R5: A read strobe loads bus_rdata at that clock edge, so the value is visible in the next cycle. bus_rdata holds its value while no read strobe is present. Reads of any address outside the decoded pair return 0xFF.
- R6: port_alt=0 decodes index/data at 0x4E/0x4F and port_alt=1 at 0x2E/0x2F. Register 0x27 reads back port_alt in bit 0, with all other bits zero.
- R7: Registers 0x20/0x21 return the chip ID high/low bytes (default 0xC3A1) and 0x22/0x23 the vendor ID high/low bytes (default 0x7B19). Writes to these registers are ignored.
- R8: Register 0x07 selects the logical device and reads back. Registers 0x30 (enable, bit 0), 0x60 (base high), 0x61 (base low) and 0x70 (IRQ select) address the bank of the selected device only, and read back that device's values.
- R9: For each device i, dev_en[i] carries that device's enable bit, dev_base[16i+15:16i] carries {base high, base low}, and dev_irq[8i+7:8i] carries the IRQ select byte.
- R10: While the selected device number is not below NUM_DEV (default 4), device registers read 0xFF and writes to them change nothing.
- R11: In device WAKE_LDN (default 3), register 0xF0 is set-only. A write ORs the data into the held value, the value reads back, and it drives wake_en.
- R12: After reset the space is locked, all device registers, the device selection, the index and wake_en are zero, and bus_rdata is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_alt | input | 1 | Strap: 0 selects the primary port pair, 1 the alternate pair |
| bus_addr | input | 16 | I/O bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered on the read strobe |
| cfg_mode | output | 1 | Configuration space open |
| dev_en | output | NUM_DEV | Per-device enable |
| dev_base | output | 16*NUM_DEV | Per-device I/O base address |
| dev_irq | output | 8*NUM_DEV | Per-device IRQ select |
| wake_en | output | 8 | Set-only wake-enable bits |

## Verification
The key sequence is tried with a lone key, with a key followed by a data-port write, with a key followed by a foreign byte on the index port, and with two back-to-back keys. These cases show whether the unlock counts consecutive writes or only counts keys. The register banks are filled with a different pattern for every device and then read back, so a bank that aliases its neighbour, or a write that leaks into an unselected device, shows up. Out-of-range device numbers, writes while locked and writes to read-only identifiers are each followed by read-back and output checks. Together these show whether an ignored access was really dropped. Swapping the strap and reading both pairs tells the decoded pair apart from the undecoded one.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    // Register numbers behind the data port
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_CHIP_HI = 8'h20;
    localparam logic [7:0] IDX_CHIP_LO = 8'h21;
    localparam logic [7:0] IDX_VEND_HI = 8'h22;
    localparam logic [7:0] IDX_VEND_LO = 8'h23;
    localparam logic [7:0] IDX_PORTSEL = 8'h27;
    localparam logic [7:0] IDX_DEV_EN  = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;
    localparam logic [7:0] IDX_WAKE    = 8'hF0;

    localparam logic [7:0] NO_DATA = 8'hFF;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    // One decoded bus cycle
    typedef struct packed {
        logic       idx_wr;
        logic       dat_wr;
        logic       idx_rd;
        logic       dat_rd;
        logic [7:0] data;
    } bus_op_t;

    // Per-device configuration
    typedef struct packed {
        logic       en;
        logic [7:0] base_hi;
        logic [7:0] base_lo;
        logic [7:0] irq;
    } dev_regs_t;

    function automatic logic is_global_idx(input logic [7:0] idx);
        return (idx == IDX_DEVSEL)  || (idx == IDX_CHIP_HI) ||
               (idx == IDX_CHIP_LO) || (idx == IDX_VEND_HI) ||
               (idx == IDX_VEND_LO) || (idx == IDX_PORTSEL);
    endfunction

endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode
    import sio_cfg_pkg::*;
#(
    parameter int         ADDR_W  = 16,
    parameter logic [15:0] PRI_IDX = 16'h004E,
    parameter logic [15:0] ALT_IDX = 16'h002E
) (
    input  logic              port_alt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output bus_op_t           op
);
    logic [ADDR_W-1:0] idx_addr;
    logic [ADDR_W-1:0] dat_addr;

    always_comb begin
        idx_addr  = port_alt ? ADDR_W'(ALT_IDX) : ADDR_W'(PRI_IDX);
        dat_addr  = idx_addr + ADDR_W'(1);
        op.idx_wr = bus_wr && (bus_addr == idx_addr);
        op.dat_wr = bus_wr && (bus_addr == dat_addr);
        op.idx_rd = bus_rd && (bus_addr == idx_addr);
        op.dat_rd = bus_rd && (bus_addr == dat_addr);
        op.data   = bus_wdata;
    end
endmodule

// File: rtl/sio_key_ctrl.sv
module sio_key_ctrl
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] EN_KEY  = 8'h87,
    parameter logic [7:0] DIS_KEY = 8'hAA
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_op_t    op,
    output logic       open,
    output logic [7:0] index
);
    key_state_e st_q;
    logic [7:0] index_q;
    logic       any_wr;
    logic       key_hit;

    assign any_wr  = op.idx_wr || op.dat_wr;
    assign key_hit = op.idx_wr && (op.data == EN_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= KEY_LOCKED;
            index_q <= '0;
        end else if (any_wr) begin
            unique case (st_q)
                KEY_LOCKED: st_q <= key_hit ? KEY_HALF : KEY_LOCKED;
                KEY_HALF:   st_q <= key_hit ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN: begin
                    if (op.idx_wr) begin
                        if (op.data == DIS_KEY) st_q <= KEY_LOCKED;
                        else                    index_q <= op.data;
                    end
                end
                default:    st_q <= KEY_LOCKED;
            endcase
        end
    end

    assign open  = (st_q == KEY_OPEN);
    assign index = index_q;
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int NUM_DEV  = 4,
    parameter int WAKE_LDN = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 open,
    input  bus_op_t              op,
    input  logic [7:0]           index,
    output logic [7:0]           ldn,
    output logic [7:0]           dev_rdata,
    output logic [NUM_DEV-1:0]   dev_en,
    output logic [16*NUM_DEV-1:0] dev_base,
    output logic [8*NUM_DEV-1:0] dev_irq,
    output logic [7:0]           wake_en
);
    dev_regs_t  regs_q [NUM_DEV];
    logic [7:0] ldn_q;
    logic [7:0] wake_q;
    logic       cfg_wr;
    logic       wake_sel;

    assign cfg_wr   = open && op.dat_wr;
    assign wake_sel = (ldn_q == 8'(WAKE_LDN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ldn_q  <= '0;
            wake_q <= '0;
        end else if (cfg_wr) begin
            if (index == IDX_DEVSEL)
                ldn_q <= op.data;
            if (wake_sel && index == IDX_WAKE)
                wake_q <= wake_q | op.data;
        end
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic mine;
        assign mine = cfg_wr && (ldn_q == 8'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (mine) begin
                unique case (index)
                    IDX_DEV_EN:  regs_q[g].en      <= op.data[0];
                    IDX_BASE_HI: regs_q[g].base_hi <= op.data;
                    IDX_BASE_LO: regs_q[g].base_lo <= op.data;
                    IDX_IRQ:     regs_q[g].irq     <= op.data;
                    default:     ;
                endcase
            end
        end

        assign dev_en[g]            = regs_q[g].en;
        assign dev_base[16*g +: 16] = {regs_q[g].base_hi, regs_q[g].base_lo};
        assign dev_irq[8*g +: 8]    = regs_q[g].irq;
    end

    // Read side: pick the selected bank
    dev_regs_t sel;
    logic      sel_ok;

    always_comb begin
        sel    = '0;
        sel_ok = 1'b0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (ldn_q == 8'(i)) begin
                sel    = regs_q[i];
                sel_ok = 1'b1;
            end
        end
        dev_rdata = NO_DATA;
        if (sel_ok) begin
            unique case (index)
                IDX_DEV_EN:  dev_rdata = {7'b0, sel.en};
                IDX_BASE_HI: dev_rdata = sel.base_hi;
                IDX_BASE_LO: dev_rdata = sel.base_lo;
                IDX_IRQ:     dev_rdata = sel.irq;
                IDX_WAKE:    dev_rdata = wake_sel ? wake_q : NO_DATA;
                default:     dev_rdata = NO_DATA;
            endcase
        end
    end

    assign ldn     = ldn_q;
    assign wake_en = wake_q;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] PRI_IDX   = 16'h004E,
    parameter logic [15:0] ALT_IDX   = 16'h002E,
    parameter logic [7:0]  EN_KEY    = 8'h87,
    parameter logic [7:0]  DIS_KEY   = 8'hAA,
    parameter logic [15:0] CHIP_ID   = 16'hC3A1,
    parameter logic [15:0] VENDOR_ID = 16'h7B19,
    parameter int          NUM_DEV   = 4,
    parameter int          WAKE_LDN  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  port_alt,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  cfg_mode,
    output logic [NUM_DEV-1:0]    dev_en,
    output logic [16*NUM_DEV-1:0] dev_base,
    output logic [8*NUM_DEV-1:0]  dev_irq,
    output logic [7:0]            wake_en
);
    bus_op_t    op;
    logic       open;
    logic [7:0] index;
    logic [7:0] ldn;
    logic [7:0] dev_rdata;
    logic [7:0] glob_rdata;
    logic [7:0] rd_next;
    logic [7:0] rdata_q;

    sio_port_decode #(
        .ADDR_W (ADDR_W),
        .PRI_IDX(PRI_IDX),
        .ALT_IDX(ALT_IDX)
    ) u_dec (
        .port_alt (port_alt),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .op       (op)
    );

    sio_key_ctrl #(
        .EN_KEY (EN_KEY),
        .DIS_KEY(DIS_KEY)
    ) u_key (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .open (open),
        .index(index)
    );

    sio_dev_bank #(
        .NUM_DEV (NUM_DEV),
        .WAKE_LDN(WAKE_LDN)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .open     (open),
        .op       (op),
        .index    (index),
        .ldn      (ldn),
        .dev_rdata(dev_rdata),
        .dev_en   (dev_en),
        .dev_base (dev_base),
        .dev_irq  (dev_irq),
        .wake_en  (wake_en)
    );

    always_comb begin
        unique case (index)
            IDX_DEVSEL:  glob_rdata = ldn;
            IDX_CHIP_HI: glob_rdata = CHIP_ID[15:8];
            IDX_CHIP_LO: glob_rdata = CHIP_ID[7:0];
            IDX_VEND_HI: glob_rdata = VENDOR_ID[15:8];
            IDX_VEND_LO: glob_rdata = VENDOR_ID[7:0];
            IDX_PORTSEL: glob_rdata = {7'b0, port_alt};
            default:     glob_rdata = NO_DATA;
        endcase

        rd_next = NO_DATA;
        if (open && op.idx_rd)
            rd_next = index;
        else if (open && op.dat_rd)
            rd_next = is_global_idx(index) ? glob_rdata : dev_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= NO_DATA;
        else if (bus_rd) rdata_q <= rd_next;
    end

    assign bus_rdata = rdata_q;
    assign cfg_mode  = open;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] PRI_IDX  = 16'h004E,
    parameter logic [15:0] ALT_IDX  = 16'h002E,
    parameter logic [7:0]  EN_KEY   = 8'h87,
    parameter logic [7:0]  DIS_KEY  = 8'hAA,
    parameter int          NUM_DEV  = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  port_alt,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [7:0]            bus_wdata,
    input logic [7:0]            bus_rdata,
    input logic                  cfg_mode,
    input logic [NUM_DEV-1:0]    dev_en,
    input logic [16*NUM_DEV-1:0] dev_base,
    input logic [8*NUM_DEV-1:0]  dev_irq,
    input logic [7:0]            wake_en
);
    logic [ADDR_W-1:0] ia;
    logic              in_pair;
    logic              key_wr;
    logic              other_wr;
    logic              armed_q;

    assign ia       = port_alt ? ADDR_W'(ALT_IDX) : ADDR_W'(PRI_IDX);
    assign in_pair  = (bus_addr == ia) || (bus_addr == ia + ADDR_W'(1));
    assign key_wr   = bus_wr && (bus_addr == ia) && (bus_wdata == EN_KEY);
    assign other_wr = bus_wr && in_pair && !key_wr;

    // Tracks whether one key write has been seen since the last foreign write
    always_ff @(posedge clk) begin
        if (rst || cfg_mode) armed_q <= 1'b0;
        else if (key_wr)     armed_q <= 1'b1;
        else if (other_wr)   armed_q <= 1'b0;
    end

    a_r1_unlock_needs_two: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_mode) |-> $past(key_wr && armed_q));

    a_r3_disable_locks: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && bus_wr && bus_addr == ia && bus_wdata == DIS_KEY) |=> !cfg_mode);

    a_r4_locked_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq) && $stable(wake_en)));

    a_r5_rdata_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    a_r5_undecoded_ff: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !in_pair) |=> (bus_rdata == 8'hFF));

    a_r11_wake_set_only: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((wake_en & $past(wake_en)) == $past(wake_en)));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .ADDR_W (ADDR_W),
    .PRI_IDX(PRI_IDX),
    .ALT_IDX(ALT_IDX),
    .EN_KEY (EN_KEY),
    .DIS_KEY(DIS_KEY),
    .NUM_DEV(NUM_DEV)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .port_alt (port_alt),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cfg_mode (cfg_mode),
    .dev_en   (dev_en),
    .dev_base (dev_base),
    .dev_irq  (dev_irq),
    .wake_en  (wake_en)
);

// File: tb/tb_sio_cfg_port.sv
module tb_sio_cfg_port;
    localparam int ND = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          port_alt = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          cfg_mode;
    logic [ND-1:0] dev_en;
    logic [16*ND-1:0] dev_base;
    logic [8*ND-1:0]  dev_irq;
    logic [7:0]    wake_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] ip = 16'h004E;
    logic [15:0] dp = 16'h004F;

    always #5 clk = ~clk;

    sio_cfg_port dut (
        .clk(clk), .rst(rst), .port_alt(port_alt), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cfg_mode(cfg_mode), .dev_en(dev_en),
        .dev_base(dev_base), .dev_irq(dev_irq), .wake_en(wake_en)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] v);
        bus_write(ip, idx);
        bus_write(dp, v);
    endtask

    task automatic cfg_read(input logic [7:0] idx, output logic [7:0] v);
        bus_write(ip, idx);
        bus_read(dp, v);
    endtask

    task automatic unlock();
        bus_write(ip, 8'h87);
        bus_write(ip, 8'h87);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R12 cfg_mode", cfg_mode, 0);
        check("R12 dev_en", dev_en, 0);
        check("R12 dev_base", dev_base, 0);
        check("R12 dev_irq", dev_irq, 0);
        check("R12 wake_en", wake_en, 0);
        check("R12 rdata", bus_rdata, 8'hFF);
        unlock();
        bus_read(ip, v);
        check("R12 index zero", v, 8'h00);
        cfg_read(8'h07, v);
        check("R12 ldn zero", v, 8'h00);
        bus_write(ip, 8'hAA);
    endtask

    task automatic t_keys();
        logic [7:0] v;
        bus_write(ip, 8'h87);
        check("R1 single key stays locked", cfg_mode, 0);
        bus_read(dp, v);
        check("R4 locked read", v, 8'hFF);
        bus_write(ip, 8'h87);
        check("R1 second key opens", cfg_mode, 1);
        bus_write(ip, 8'h20);
        bus_write(ip, 8'hAA);
        check("R3 disable key locks", cfg_mode, 0);
        // interrupted by a data write
        bus_write(ip, 8'h87);
        bus_write(dp, 8'h00);
        bus_write(ip, 8'h87);
        check("R2 data write restarts", cfg_mode, 0);
        bus_write(ip, 8'h87);
        check("R2 two fresh keys open", cfg_mode, 1);
        bus_read(ip, v);
        check("R3 index kept over lock", v, 8'h20);
        bus_write(ip, 8'hAA);
        // interrupted by a foreign index byte
        bus_write(ip, 8'h87);
        bus_write(ip, 8'h55);
        bus_write(ip, 8'h87);
        check("R2 foreign byte restarts", cfg_mode, 0);
        bus_write(ip, 8'h87);
        check("R2 reopen", cfg_mode, 1);
        bus_write(ip, 8'hAA);
    endtask

    task automatic t_locked_ignore();
        logic [7:0] v;
        bus_write(ip, 8'h60);
        bus_write(dp, 8'h12);
        bus_write(dp, 8'h34);
        check("R4 locked write base", dev_base, 0);
        check("R4 locked write en", dev_en, 0);
        bus_read(dp, v);
        check("R4 locked data read", v, 8'hFF);
        bus_read(ip, v);
        check("R5 locked index read", v, 8'hFF);
    endtask

    task automatic t_ids();
        logic [7:0] v;
        unlock();
        cfg_read(8'h20, v); check("R7 chip hi", v, 8'hC3);
        cfg_read(8'h21, v); check("R7 chip lo", v, 8'hA1);
        cfg_read(8'h22, v); check("R7 vendor hi", v, 8'h7B);
        cfg_read(8'h23, v); check("R7 vendor lo", v, 8'h19);
        cfg_write(8'h20, 8'h00);
        cfg_read(8'h20, v); check("R7 chip write ignored", v, 8'hC3);
        cfg_read(8'h27, v); check("R6 portsel primary", v, 8'h00);
        bus_write(ip, 8'hAA);
    endtask

    task automatic t_devices();
        logic [7:0] v;
        unlock();
        for (int i = 0; i < ND; i++) begin
            cfg_write(8'h07, 8'(i));
            cfg_write(8'h30, 8'((i % 2 == 0) ? 1 : 0));
            cfg_write(8'h60, 8'(8'h03 + i));
            cfg_write(8'h61, 8'(8'h10 * (i + 1)));
            cfg_write(8'h70, 8'(i + 3));
        end
        for (int i = 0; i < ND; i++) begin
            cfg_write(8'h07, 8'(i));
            cfg_read(8'h07, v); check("R8 ldn readback", v, 8'(i));
            cfg_read(8'h30, v); check("R8 en readback", v, 8'((i % 2 == 0) ? 1 : 0));
            cfg_read(8'h60, v); check("R8 base hi readback", v, 8'(8'h03 + i));
            cfg_read(8'h61, v); check("R8 base lo readback", v, 8'(8'h10 * (i + 1)));
            cfg_read(8'h70, v); check("R8 irq readback", v, 8'(i + 3));
            check("R9 dev_en bit", dev_en[i], (i % 2 == 0) ? 1 : 0);
            check("R9 dev_base", dev_base[16*i +: 16], {8'(8'h03 + i), 8'(8'h10 * (i + 1))});
            check("R9 dev_irq", dev_irq[8*i +: 8], 8'(i + 3));
        end
        bus_write(ip, 8'hAA);
    endtask

    task automatic t_bad_ldn();
        logic [7:0] v;
        logic [16*ND-1:0] base0;
        logic [8*ND-1:0]  irq0;
        base0 = dev_base; irq0 = dev_irq;
        unlock();
        cfg_write(8'h07, 8'h09);
        cfg_write(8'h60, 8'h55);
        cfg_write(8'h70, 8'h0E);
        cfg_read(8'h60, v);
        check("R10 out-of-range read", v, 8'hFF);
        check("R10 base unchanged", dev_base, base0);
        check("R10 irq unchanged", dev_irq, irq0);
        bus_write(ip, 8'hAA);
    endtask

    task automatic t_wake();
        logic [7:0] v;
        unlock();
        cfg_write(8'h07, 8'h03);
        cfg_write(8'hF0, 8'h05);
        cfg_write(8'hF0, 8'h02);
        cfg_read(8'hF0, v);
        check("R11 wake OR", v, 8'h07);
        cfg_write(8'hF0, 8'h00);
        cfg_read(8'hF0, v);
        check("R11 wake no clear", v, 8'h07);
        check("R11 wake_en port", wake_en, 8'h07);
        cfg_write(8'h07, 8'h01);
        cfg_write(8'hF0, 8'hF0);
        check("R11 other device no wake", wake_en, 8'h07);
        bus_write(ip, 8'hAA);
    endtask

    task automatic t_ports();
        logic [7:0] v;
        unlock();
        bus_write(ip, 8'h27);
        bus_read(16'h002F, v);
        check("R5 other pair reads FF", v, 8'hFF);
        repeat (3) @(negedge clk);
        check("R5 rdata holds", bus_rdata, 8'hFF);
        bus_read(ip, v);
        check("R3 index readback", v, 8'h27);
        repeat (3) @(negedge clk);
        check("R5 rdata holds value", bus_rdata, 8'h27);
        port_alt = 1'b1;
        ip = 16'h002E; dp = 16'h002F;
        bus_read(dp, v);
        check("R6 portsel alternate", v, 8'h01);
        bus_read(16'h004F, v);
        check("R6 primary undecoded", v, 8'hFF);
        bus_read(16'h1234, v);
        check("R5 foreign address", v, 8'hFF);
        bus_write(ip, 8'hAA);
        check("R6 lock on alternate", cfg_mode, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_keys();
        t_locked_ignore();
        t_ids();
        t_devices();
        t_bad_ldn();
        t_wake();
        t_ports();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule